// File: doc/BRIEF.md
# Clock Reference Selector

This block picks one timing source out of four candidates to discipline a node's central oscillator. The candidates are a building timing input (`bits`), two line-recovered references (`ref1`, `ref2`) and a packet-timing reference (`ptp`). Each candidate has three inputs: a qualification flag from its monitor, a received 4-bit quality level code, and an optional quality override that replaces the received code.

A configuration write sets the priority ranking of the four candidates and the selection mode. In strict-priority mode the top-ranked usable candidate wins. In quality mode the best quality wins, and the ranking breaks ties. The block drives the chosen index, a valid flag and the effective quality of the chosen candidate. A downstream loop uses the valid flag to decide whether to enter holdover. A one-cycle event marks every change of the selection.

Top module: `clk_ref_select`

## Requirements
- R1: While `rst_n` is low, and after it is released with no usable candidate, `sel_valid` is 0, `sel_idx` is 0, `sel_ql` is 15 and `sel_switch` is 0. The ranking resets to bits, ref1, ref2, ptp and the mode resets to strict priority.
- R2: A candidate is usable only if its qualification flag is 1 and its effective quality code is not 15. Code 15 means do-not-use. An unusable candidate is never selected.
- R3: When `ovr_en[i]` is 1, `ovr_ql[4i+3:4i]` replaces `cand_ql[4i+3:4i]` as candidate i's effective quality. The replacement applies both in the comparison and on `sel_ql`.
- R4: With mode 0, the selection is the highest-ranked usable candidate, whatever the quality codes are.
- R5: With mode 1, the selection is the usable candidate with the numerically lowest effective quality code. A lower code means better quality. Among equal codes, the higher-ranked candidate wins.
- R6: Candidate indices are bits=0, ref1=1, ref2=2, ptp=3. `cfg_order[2k+1:2k]` holds the index at rank k, and rank 0 is the highest. `cfg_mode` 0 selects strict priority and 1 selects quality first.
- R7: A configuration write (`cfg_we`=1) whose order repeats any index is discarded as a whole. In that case both the previous order and the previous mode stay in force.
- R8: When no candidate is usable, `sel_valid` is 0, `sel_ql` is 15 and `sel_idx` keeps its last value.
- R9: Candidate inputs and configuration are sampled at a rising edge. The outputs reflect them right after that edge and not before.
- R10: `sel_switch` is 1 for exactly the cycle in which the pair (`sel_valid`, `sel_idx`) differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cand_ok | input | 4 | qualification flag per candidate |
| cand_ql | input | 16 | received quality code, 4 bits per candidate |
| ovr_en | input | 4 | quality override enable per candidate |
| ovr_ql | input | 16 | override quality code, 4 bits per candidate |
| cfg_we | input | 1 | configuration write strobe |
| cfg_order | input | 8 | ranking, 2-bit index per rank |
| cfg_mode | input | 1 | 0 strict priority, 1 quality first |
| sel_idx | output | 2 | selected candidate index |
| sel_valid | output | 1 | a usable candidate is selected |
| sel_ql | output | 4 | effective quality of the selection |
| sel_switch | output | 1 | one-cycle selection change event |

## Verification
A corrupted ranking register or a discarded write that was wrongly accepted shows up as a different `sel_idx` on the very next cycle. It only shows when the candidates carry distinct quality codes, or when the top-ranked candidate is usable, so the vectors mix both situations. A stale copy of the last selection shows up in two ways: as a missing or lingering `sel_switch` one cycle after a change, and as a wrong held index once every candidate is dropped. A wrong override path shows up as a `sel_ql` value that differs from the override code in the same cycle as the selection.

// File: rtl/clk_ref_select.sv
module clk_ref_select #(
  parameter int N_REF = 4,
  parameter int QL_W = 4,
  parameter logic [QL_W-1:0] QL_DNU = '1,
  parameter logic [2*N_REF-1:0] ORDER_RST = 8'hE4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_REF-1:0]       cand_ok,
  input  logic [N_REF*QL_W-1:0]  cand_ql,
  input  logic [N_REF-1:0]       ovr_en,
  input  logic [N_REF*QL_W-1:0]  ovr_ql,
  input  logic                   cfg_we,
  input  logic [2*N_REF-1:0]     cfg_order,
  input  logic                   cfg_mode,
  output logic [1:0]             sel_idx,
  output logic                   sel_valid,
  output logic [QL_W-1:0]        sel_ql,
  output logic                   sel_switch
);
  localparam int IW = $clog2(N_REF);

  logic [N_REF-1:0]      ok_q, oen_q;
  logic [N_REF*QL_W-1:0] ql_q, oql_q;
  logic [2*N_REF-1:0]    order_q;
  logic                  mode_q;
  logic [IW-1:0]         last_idx;
  logic                  last_valid;

  logic [QL_W-1:0] eff [N_REF];
  logic [N_REF-1:0] elig;
  logic            any;
  logic [IW-1:0]   best;
  logic [QL_W-1:0] bql;

  function automatic logic is_perm(input logic [2*N_REF-1:0] o);
    logic [N_REF-1:0] m;
    m = '0;
    for (int k = 0; k < N_REF; k++) m[o[k*IW +: IW]] = 1'b1;
    return &m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= '0;
      oen_q <= '0;
      ql_q <= '0;
      oql_q <= '0;
      order_q <= ORDER_RST;
      mode_q <= 1'b0;
      last_idx <= '0;
      last_valid <= 1'b0;
    end else begin
      ok_q <= cand_ok;
      oen_q <= ovr_en;
      ql_q <= cand_ql;
      oql_q <= ovr_ql;
      if (cfg_we && is_perm(cfg_order)) begin
        order_q <= cfg_order;
        mode_q <= cfg_mode;
      end
      last_idx <= sel_idx;
      last_valid <= sel_valid;
    end
  end

  for (genvar i = 0; i < N_REF; i++) begin : g_eff
    assign eff[i]  = oen_q[i] ? oql_q[i*QL_W +: QL_W] : ql_q[i*QL_W +: QL_W];
    assign elig[i] = ok_q[i] && (eff[i] != QL_DNU);
  end

  always_comb begin
    any = 1'b0;
    best = '0;
    bql = QL_DNU;
    for (int k = 0; k < N_REF; k++) begin
      if (elig[order_q[k*IW +: IW]] &&
          (!any || (mode_q && eff[order_q[k*IW +: IW]] < bql))) begin
        any = 1'b1;
        best = order_q[k*IW +: IW];
        bql = eff[order_q[k*IW +: IW]];
      end
    end
  end

  assign sel_valid  = any;
  assign sel_idx    = any ? best : last_idx;
  assign sel_ql     = any ? bql : QL_DNU;
  assign sel_switch = (any != last_valid) || (any && best != last_idx);

  AST_VALID_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> elig[sel_idx]); // R2
  AST_QL_USABLE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> sel_ql != QL_DNU); // R2
  AST_HOLD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> sel_idx == $past(sel_idx)); // R8
  AST_SWITCH_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid != $past(sel_valid)) |-> sel_switch); // R10
  AST_ORDER_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    is_perm(order_q)); // R7
endmodule

// File: tb/test_clk_ref_select.sv
module test_clk_ref_select;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cand_ok = '0, ovr_en = '0;
  logic [15:0] cand_ql = '0, ovr_ql = '0;
  logic cfg_we = 1'b0, cfg_mode = 1'b0;
  logic [7:0] cfg_order = 8'hE4;
  logic [1:0] sel_idx;
  logic sel_valid, sel_switch;
  logic [3:0] sel_ql;
  int checks = 0, errors = 0;
  logic pv = 1'b0;
  logic [1:0] pi = 2'd0;

  always #4 clk = ~clk;

  clk_ref_select i_clk_ref_select (
    .clk(clk), .rst_n(rst_n), .cand_ok(cand_ok), .cand_ql(cand_ql),
    .ovr_en(ovr_en), .ovr_ql(ovr_ql), .cfg_we(cfg_we), .cfg_order(cfg_order),
    .cfg_mode(cfg_mode), .sel_idx(sel_idx), .sel_valid(sel_valid),
    .sel_ql(sel_ql), .sel_switch(sel_switch));

  // {ok, ql, ovr_en, ovr_ql, order, mode, exp_valid, exp_idx, exp_ql}
  localparam int NV = 10;
  localparam logic [55:0] VEC [NV] = '{
    {4'hF,16'h1234,4'h0,16'h0000,8'hE4,1'b0,1'b1,2'd0,4'h4}, // R4
    {4'hF,16'h1234,4'h0,16'h0000,8'hE4,1'b1,1'b1,2'd3,4'h1}, // R5
    {4'hF,16'h2222,4'h0,16'h0000,8'h1B,1'b1,1'b1,2'd3,4'h2}, // R5 R6 tie
    {4'hE,16'h1234,4'h0,16'h0000,8'hE4,1'b0,1'b1,2'd1,4'h3}, // R2 unqualified
    {4'hF,16'h123F,4'h0,16'h0000,8'hE4,1'b0,1'b1,2'd1,4'h3}, // R2 do-not-use
    {4'hF,16'h1234,4'h1,16'h0000,8'hE4,1'b1,1'b1,2'd0,4'h0}, // R3
    {4'hF,16'h1111,4'h2,16'h00F0,8'hE1,1'b0,1'b1,2'd0,4'h1}, // R3 R6
    {4'h0,16'h1111,4'h0,16'h0000,8'hE4,1'b0,1'b0,2'd0,4'hF}, // R8
    {4'h4,16'h0500,4'h0,16'h0000,8'hE4,1'b1,1'b1,2'd2,4'h5}, // R5
    {4'hF,16'h3333,4'hF,16'h9871,8'h1B,1'b1,1'b1,2'd0,4'h1}  // R3
  };

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic chk_sel(input string r, input logic v, input logic [1:0] i, input logic [3:0] q);
    logic sw;
    sw = (v != pv) || (v && i != pi);
    chk({r, " valid"}, int'(sel_valid), int'(v));
    chk({r, " idx"}, int'(sel_idx), int'(i));
    chk({r, " ql"}, int'(sel_ql), int'(q));
    chk({r, " R10 switch"}, int'(sel_switch), int'(sw));
    pv = v;
    pi = i;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 reset valid", int'(sel_valid), 0);
    chk("R1 reset idx", int'(sel_idx), 0);
    chk("R1 reset ql", int'(sel_ql), 15);
    chk("R1 reset switch", int'(sel_switch), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_sel("R1 after release", 1'b0, 2'd0, 4'hF);

    for (int n = 0; n < NV; n++) begin
      {cand_ok, cand_ql, ovr_en, ovr_ql, cfg_order, cfg_mode} = VEC[n][55:7];
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      chk_sel($sformatf("vector %0d", n), VEC[n][6], VEC[n][5:4], VEC[n][3:0]);
    end

    // R8: hold a nonzero index in holdover (order 1B, mode 1 in force)
    cand_ok = 4'h4; cand_ql = 16'h0500; ovr_en = 4'h0;
    @(negedge clk);
    chk_sel("R8 setup", 1'b1, 2'd2, 4'h5);
    cand_ok = 4'h0;
    @(negedge clk);
    chk_sel("R8 holdover", 1'b0, 2'd2, 4'hF);
    @(negedge clk);
    chk_sel("R8 holdover steady", 1'b0, 2'd2, 4'hF);

    // R7: a repeated index discards the whole write
    cand_ok = 4'hF; cand_ql = 16'h1234;
    cfg_order = 8'hE4; cfg_mode = 1'b0; cfg_we = 1'b1;
    @(negedge clk);
    chk_sel("R7 setup", 1'b1, 2'd0, 4'h4);
    cfg_order = 8'hE0; cfg_mode = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    chk_sel("R7 rejected write", 1'b1, 2'd0, 4'h4);
    @(negedge clk);
    chk_sel("R7 rejected steady", 1'b1, 2'd0, 4'h4);

    // R9 latency and R10 pulse width
    cand_ok = 4'hE;
    #1;
    chk("R9 before edge idx", int'(sel_idx), 0);
    chk("R9 before edge switch", int'(sel_switch), 0);
    @(negedge clk);
    chk_sel("R9 after edge", 1'b1, 2'd1, 4'h3);
    @(negedge clk);
    chk_sel("R10 pulse ends", 1'b1, 2'd1, 4'h3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule